// File: doc/BRIEF.md
# Shared-Adder Four-Function ALU

This block is a purely combinational 8-bit arithmetic logic unit. It takes two operands and a 2-bit function code. It returns one of four results: the bitwise AND, the bitwise OR, the sum, or the difference of the operands. It also returns a carry-out and a signed overflow flag. It has no clock and no state, so it can sit inside any pipeline stage of a larger datapath.

A single ripple-carry adder serves both arithmetic operations. The low function bit picks logic versus arithmetic. The high function bit does two jobs: it picks the second operation of each pair, and it also inverts operand B at the adder input and sets the adder carry-in. Subtraction is therefore computed as A plus the inverted B plus one. The logic results are masked by the function decode, and a tree of three two-way selectors picks the output.

Top module: `alu4f_core`

## Requirements
- R1: With `func_sel` = 2'b00, `result` equals `opnd_a & opnd_b`.
- R2: With `func_sel` = 2'b10, `result` equals `opnd_a | opnd_b`. The B inversion that is active under this code does not reach the logic result.
- R3: With `func_sel` = 2'b01, `result` equals `(opnd_a + opnd_b) mod 256`, and `carry_out` is bit 8 of the unbounded sum.
- R4: With `func_sel` = 2'b11, `result` equals `(opnd_a - opnd_b) mod 256`, and `carry_out` is 1 exactly when `opnd_a >= opnd_b` as unsigned values (no borrow).
- R5: For the arithmetic codes (`func_sel[0]` = 1), `ovf_flag` is 1 exactly when the two's-complement result of the operation does not fit in 8 signed bits. This is the same as the carry into bit 7 differing from the carry out of bit 7.
- R6: For the logic codes (`func_sel[0]` = 0), `ovf_flag` is 0.
- R7: For the logic codes, `carry_out` still reports the shared adder's carry. Under 2'b00 this is the carry of A+B. Under 2'b10 it is the carry of A + ~B + 1.
- R8: The outputs depend only on the current inputs. A change of any input is visible at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand; inverted at the adder for subtraction |
| func_sel | input | 2 | Function code: 00 AND, 10 OR, 01 add, 11 subtract |
| result | output | 8 | Selected operation result |
| carry_out | output | 1 | Carry from the last adder stage |
| ovf_flag | output | 1 | Signed overflow, arithmetic codes only |

## Verification
The operand pairs come from the values 0x00, 0x01, 0x55, 0x7F, 0x80, 0xAA and 0xFF, and each pair is tried under all four codes.

- Pairs made of 0x7F and 0x80 separate the carry into bit 7 from the carry out of it, which is what exposes a wrong overflow term.
- Pairs with 0xFF, and pairs of equal operands, show whether the carry-in is applied for subtraction and whether the no-borrow sense of the carry is right.
- The complementary patterns 0x55 and 0xAA separate AND from OR. They would also reveal an inverted B leaking into the logic path.
- A mid-cycle input change with no clock edge shows that the block holds no state.

// File: rtl/alu4f_pkg.sv
package alu4f_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_ADD = 2'b01,
        FN_OR  = 2'b10,
        FN_SUB = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic sum;
        logic cy;
    } fa_res_t;

    // one-bit full adder equation
    function automatic fa_res_t fa_eval(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.sum = x ^ y ^ ci;
        r.cy  = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/alu4f_bit_fa.sv
module alu4f_bit_fa
    import alu4f_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    fa_res_t r;

    always_comb begin
        r   = fa_eval(x_i, y_i, c_i);
        s_o = r.sum;
        c_o = r.cy;
    end
endmodule

// File: rtl/alu4f_ripple.sv
module alu4f_ripple #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cmsb_o
);
    localparam int unsigned TOP = W - 1;

    logic [W:0] chain;

    assign chain[0] = cin_i;

    generate
        for (genvar k = 0; k < W; k++) begin : g_stage
            alu4f_bit_fa u_fa (
                .x_i (x_i[k]),
                .y_i (y_i[k]),
                .c_i (chain[k]),
                .s_o (sum_o[k]),
                .c_o (chain[k+1])
            );
        end
    endgenerate

    assign cout_o = chain[W];
    assign cmsb_o = chain[TOP];
endmodule

// File: rtl/alu4f_sel2.sv
module alu4f_sel2 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] d0_i,
    input  logic [W-1:0] d1_i,
    input  logic         s_i,
    output logic [W-1:0] y_o
);
    assign y_o = s_i ? d1_i : d0_i;
endmodule

// File: rtl/alu4f_core.sv
module alu4f_core
    import alu4f_pkg::*;
(
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic [1:0] func_sel,
    output logic [7:0] result,
    output logic       carry_out,
    output logic       ovf_flag
);
    localparam int unsigned W = DATA_W;

    logic          arith_sel;
    logic          inv_sel;
    logic [W-1:0]  b_cond;
    logic [W-1:0]  add_sum;
    logic          add_cout;
    logic          add_cmsb;
    logic [W-1:0]  and_gated;
    logic [W-1:0]  or_gated;
    logic [W-1:0]  lvl_lo;
    logic [W-1:0]  lvl_hi;

    assign arith_sel = func_sel[0];
    assign inv_sel   = func_sel[1];

    // switched inverter on B feeds the adder only
    assign b_cond = opnd_b ^ {W{inv_sel}};

    alu4f_ripple #(.W(W)) u_add (
        .x_i    (opnd_a),
        .y_i    (b_cond),
        .cin_i  (inv_sel),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .cmsb_o (add_cmsb)
    );

    // logic results masked by the function decode
    assign and_gated = (opnd_a & opnd_b) & {W{~arith_sel & ~inv_sel}};
    assign or_gated  = (opnd_a | opnd_b) & {W{~arith_sel &  inv_sel}};

    // three two-way selectors: func_sel[0] inside each pair, func_sel[1] across
    alu4f_sel2 #(.W(W)) u_sel_lo (
        .d0_i (and_gated), .d1_i (add_sum), .s_i (arith_sel), .y_o (lvl_lo)
    );
    alu4f_sel2 #(.W(W)) u_sel_hi (
        .d0_i (or_gated),  .d1_i (add_sum), .s_i (arith_sel), .y_o (lvl_hi)
    );
    alu4f_sel2 #(.W(W)) u_sel_out (
        .d0_i (lvl_lo),    .d1_i (lvl_hi),  .s_i (inv_sel),   .y_o (result)
    );

    assign carry_out = add_cout;
    assign ovf_flag  = arith_sel & (add_cmsb ^ add_cout);

    // checks on the settled outputs
    always_comb begin
        if (func_sel == FN_AND) begin
            p_and_result_r1: assert (result == (opnd_a & opnd_b))
                else $error("R1 AND result mismatch");
        end
        if (func_sel == FN_OR) begin
            p_or_result_r2: assert (result == (opnd_a | opnd_b))
                else $error("R2 OR result mismatch");
        end
        if (func_sel == FN_ADD) begin
            p_add_sum_r3: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
                else $error("R3 add mismatch");
            p_add_ovf_r5: assert (ovf_flag == ((opnd_a[7] == opnd_b[7]) && (result[7] != opnd_a[7])))
                else $error("R5 add overflow mismatch");
        end
        if (func_sel == FN_SUB) begin
            p_sub_borrow_r4: assert (carry_out == (opnd_a >= opnd_b))
                else $error("R4 borrow sense mismatch");
            p_sub_ovf_r5: assert (ovf_flag == ((opnd_a[7] != opnd_b[7]) && (result[7] != opnd_a[7])))
                else $error("R5 sub overflow mismatch");
        end
        if (!func_sel[0]) begin
            p_no_overflow_r6: assert (!ovf_flag)
                else $error("R6 overflow during logic op");
        end
    end
endmodule

// File: tb/sim_alu4f_core.sv
module sim_alu4f_core;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_s;
    logic [7:0] b_s;
    logic [1:0] f_s;
    logic [7:0] res_w;
    logic       cy_w;
    logic       ov_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5ns clk = ~clk;

    alu4f_core u0 (
        .opnd_a    (a_s),
        .opnd_b    (b_s),
        .func_sel  (f_s),
        .result    (res_w),
        .carry_out (cy_w),
        .ovf_flag  (ov_w)
    );

    // {func, a, b, exp_result, exp_carry, exp_ovf}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 8'hF0, 8'h3C, 8'h30, 1'b1, 1'b0},
        {2'b10, 8'hF0, 8'h0F, 8'hFF, 1'b1, 1'b0},
        {2'b01, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},
        {2'b01, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
        {2'b01, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
        {2'b11, 8'h00, 8'h01, 8'hFF, 1'b0, 1'b0},
        {2'b11, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},
        {2'b11, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1},
        {2'b11, 8'h55, 8'h55, 8'h00, 1'b1, 1'b0},
        {2'b00, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b0},
        {2'b10, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},
        {2'b01, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0}
    };

    localparam logic [7:0] CORNER [7] = '{8'h00, 8'h01, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFF};

    task automatic check(input string tag, input logic [7:0] er, input logic ec, input logic ev);
        n_cmp++;
        if (res_w !== er || cy_w !== ec || ov_w !== ev) begin
            n_bad++;
            $display("FAIL %s f=%b a=%h b=%h: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                     tag, f_s, a_s, b_s, res_w, cy_w, ov_w, er, ec, ev);
        end
    endtask

    function automatic string tag_of(input logic [1:0] f);
        case (f)
            2'b00:   return "R1/R6/R7";
            2'b10:   return "R2/R6/R7";
            2'b01:   return "R3/R5";
            default: return "R4/R5";
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        a_s = 8'h00;
        b_s = 8'h00;
        f_s = 2'b00;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state: zero operands under AND give zero, carry of 0+0 is 0
        check("R1 reset", 8'h00, 1'b0, 1'b0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            f_s = VEC[i][27:26];
            a_s = VEC[i][25:18];
            b_s = VEC[i][17:10];
            @(negedge clk);
            check(tag_of(f_s), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // corner pairs against a behavioural reference
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    logic [7:0] bb;
                    logic [8:0] s9;
                    logic [7:0] er;
                    logic       ev;
                    @(posedge clk);
                    f_s = 2'(f);
                    a_s = CORNER[i];
                    b_s = CORNER[j];
                    bb  = f_s[1] ? ~b_s : b_s;
                    s9  = {1'b0, a_s} + {1'b0, bb} + {8'h00, f_s[1]};
                    case (f_s)
                        2'b00:   er = a_s & b_s;
                        2'b10:   er = a_s | b_s;
                        default: er = s9[7:0];
                    endcase
                    ev = f_s[0] & (a_s[7] == bb[7]) & (s9[7] != a_s[7]);
                    @(negedge clk);
                    check(tag_of(f_s), er, s9[8], ev);
                end
            end
        end

        // R8: change inputs mid-cycle, no clock edge before sampling
        @(negedge clk);
        f_s = 2'b11; a_s = 8'h10; b_s = 8'h20;
        #1ns;
        check("R8 sub no-edge", 8'hF0, 1'b0, 1'b0);
        f_s = 2'b01;
        #1ns;
        check("R8 add no-edge", 8'h30, 1'b0, 1'b0);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
        end
    end

endmodule